// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost Flags

This block carries 18-bit words from a write clock domain to an unrelated read clock domain. The depth is a parameter and must be a power of two. The write and read enables are active low. The block reports five active-low status flags: empty, full, half-full, almost-empty and almost-full. The almost thresholds are held in two offset registers. Software reaches these registers through the ordinary data ports while a load control is held low.

The block has no ready/valid handshake; the flags provide the back-pressure.
- A producer may present a word whenever `full_n` is high. A write attempted while `full_n` is low is dropped.
- A consumer may pull a word whenever `empty_n` is high. A read attempted while `empty_n` is low leaves the output register as it was.

A retransmit strobe moves the read pointer back to the first location written since reset, so that the data can be read again. A mode input chooses how the almost flags are produced:
- registered in their own clock domain, or
- formed combinationally from the raw pointers of both domains.

Top module: `dual_clock_fifo`

## Requirements
- R1: On a rising `wclk` edge with `wr_en_n` low, `load_n` high and `full_n` high, `wr_data` is stored as the next word. A write attempted while `full_n` is low stores nothing and leaves the FIFO contents unchanged.
- R2: On a rising `rclk` edge with `rd_en_n` low, `load_n` high, `rt_n` high and `empty_n` high, `rd_data` takes the oldest stored word, so words come out in write order. A read attempted while `empty_n` is low leaves `rd_data` unchanged.
- R3: On a rising `wclk` edge with `load_n` and `wr_en_n` both low, the low PW bits of `wr_data` go into an offset register, where PW = log2(DEPTH)+1. The first such access writes the almost-empty offset, the next writes the almost-full offset, and the order keeps alternating. The FIFO contents and its pointers are untouched.
- R4: On a rising `rclk` edge with `load_n` and `rd_en_n` both low, `rd_data` takes an offset value, zero-extended. The order is almost-empty first, then almost-full, alternating. The read side keeps its own order, separate from the write side.
- R5: `empty_n` is low exactly when the fill level seen in the read domain is 0.
- R6: `full_n` is low exactly when the fill level seen in the write domain equals DEPTH.
- R7: `half_n` is low when the fill level seen in the write domain exceeds DEPTH/2.
- R8: `aempty_n` is low when the fill level is at or below the almost-empty offset. `afull_n` is low when DEPTH minus the fill level is at or below the almost-full offset.
- R9: With `sync_almost` = 1, `aempty_n` is a register in the `rclk` domain and `afull_n` is a register in the `wclk` domain. Either flag reacts to a pointer change from the other domain no sooner than the third edge of its own clock. With `sync_almost` = 0, both flags follow the raw pointers without any clock delay.
- R10: While `rst_n` is low, the FIFO empties and both offsets return to 7. Both access orders restart at the almost-empty offset. The flags then read `empty_n`=0, `full_n`=1, `half_n`=1, `aempty_n`=0, `afull_n`=1.
- R11: On a rising `rclk` edge with `rt_n` low, the read pointer returns to the first location written since reset, and this overrides any read on that edge. The words are then read again in the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en_n | input | 1 | Write enable, active low |
| wr_data | input | 18 | Write word, or offset value during load |
| load_n | input | 1 | Offset register access, active low |
| rd_en_n | input | 1 | Read enable, active low |
| rd_data | output | 18 | Read word, or offset value during load |
| rt_n | input | 1 | Retransmit strobe, active low |
| sync_almost | input | 1 | 1: registered almost flags, 0: combinational |
| empty_n | output | 1 | Empty flag (read domain), active low |
| full_n | output | 1 | Full flag (write domain), active low |
| half_n | output | 1 | Half-full flag (write domain), active low |
| aempty_n | output | 1 | Almost-empty flag, active low |
| afull_n | output | 1 | Almost-full flag, active low |

## Verification
A write updates the write pointer on its own `wclk` edge. The read domain sees that change two `rclk` edges later, which is when `empty_n` reacts. A registered `aempty_n` reacts one `rclk` edge after that. Moves of the read pointer reach `full_n`, `half_n` and registered `afull_n` with the same two- and three-edge lag in `wclk`. `rd_data` changes on the `rclk` edge that performs the read. The bench drives inputs on falling edges and samples `rd_data` on the next falling edge. Before any flag check it waits six edges of each clock. Two checks are placed deliberately half a write cycle after a write edge, to show the difference between the combinational and the registered almost flags.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;
  localparam int DATA_W      = 18;
  localparam int OFS_DEFAULT = 7;

  // which offset register the next load access touches
  typedef enum logic {SEL_AE = 1'b0, SEL_AF = 1'b1} ofs_sel_e;
endpackage

// File: rtl/dcfifo_sync.sv
module dcfifo_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/dcfifo_gray2bin.sv
module dcfifo_gray2bin #(
  parameter int W = 5
) (
  input  logic [W-1:0] gray,
  output logic [W-1:0] bin
);
  always_comb begin
    bin[W-1] = gray[W-1];
    for (int i = W - 2; i >= 0; i--) begin
      bin[i] = bin[i+1] ^ gray[i];
    end
  end
endmodule

// File: rtl/dcfifo_mem.sv
module dcfifo_mem #(
  parameter int DW    = 18,
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] ram [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) ram[waddr] <= wdata;
  end

  assign rdata = ram[raddr];
endmodule

// File: rtl/dcfifo_wr_ctl.sv
module dcfifo_wr_ctl
  import dcfifo_pkg::*;
#(
  parameter int DW      = 18,
  parameter int DEPTH   = 16,
  parameter int PW      = 5,
  parameter int OFS_RST = 7
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          wr_en_n,
  input  logic          load_n,
  input  logic [DW-1:0] wr_data,
  input  logic [PW-1:0] rd_gray_s,
  output logic [PW-1:0] wr_bin,
  output logic [PW-1:0] wr_gray,
  output logic          mem_we,
  output logic          full_n,
  output logic          half_n,
  output logic          afull_reg_n,
  output logic [PW-1:0] ae_ofs,
  output logic [PW-1:0] af_ofs
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_P  = PW'(DEPTH / 2);
  localparam logic [PW-1:0] OFS_R   = PW'(OFS_RST);

  logic [PW-1:0] rd_bin_w;
  logic [PW-1:0] fill_w;
  logic [PW-1:0] wr_next;
  logic          is_full;
  logic          ofs_wr;
  logic          af_q;
  ofs_sel_e      wsel;

  dcfifo_gray2bin #(.W(PW)) u_rconv (.gray(rd_gray_s), .bin(rd_bin_w));

  assign fill_w  = wr_bin - rd_bin_w;
  assign is_full = (fill_w == DEPTH_P);
  assign wr_next = wr_bin + 1'b1;
  assign mem_we  = !wr_en_n && load_n && !is_full;
  assign ofs_wr  = !wr_en_n && !load_n;

  assign full_n      = !is_full;
  assign half_n      = !(fill_w > HALF_P);
  assign afull_reg_n = !af_q;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wr_bin  <= '0;
      wr_gray <= '0;
      af_q    <= 1'b0;
      wsel    <= SEL_AE;
      ae_ofs  <= OFS_R;
      af_ofs  <= OFS_R;
    end else begin
      af_q <= ((DEPTH_P - fill_w) <= af_ofs);
      if (mem_we) begin
        wr_bin  <= wr_next;
        wr_gray <= wr_next ^ (wr_next >> 1);
      end
      if (ofs_wr) begin
        if (wsel == SEL_AE) ae_ofs <= wr_data[PW-1:0];
        else                af_ofs <= wr_data[PW-1:0];
        wsel <= (wsel == SEL_AE) ? SEL_AF : SEL_AE;
      end
    end
  end
endmodule

// File: rtl/dcfifo_rd_ctl.sv
module dcfifo_rd_ctl
  import dcfifo_pkg::*;
#(
  parameter int DW = 18,
  parameter int PW = 5
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          rd_en_n,
  input  logic          load_n,
  input  logic          rt_n,
  input  logic [PW-1:0] wr_gray_s,
  input  logic [PW-1:0] ae_ofs,
  input  logic [PW-1:0] af_ofs,
  input  logic [DW-1:0] mem_q,
  output logic [PW-1:0] rd_bin,
  output logic [PW-1:0] rd_gray,
  output logic [DW-1:0] rd_data,
  output logic          empty_n,
  output logic          aempty_reg_n
);
  logic [PW-1:0] wr_bin_r;
  logic [PW-1:0] fill_r;
  logic [PW-1:0] rd_next;
  logic          is_empty;
  logic          rd_go;
  logic          ofs_rd;
  logic          ae_q;
  ofs_sel_e      rsel;

  dcfifo_gray2bin #(.W(PW)) u_wconv (.gray(wr_gray_s), .bin(wr_bin_r));

  assign fill_r   = wr_bin_r - rd_bin;
  assign is_empty = (fill_r == '0);
  assign rd_next  = rd_bin + 1'b1;
  assign rd_go    = !rd_en_n && load_n && rt_n && !is_empty;
  assign ofs_rd   = !rd_en_n && !load_n;

  assign empty_n      = !is_empty;
  assign aempty_reg_n = !ae_q;

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rd_bin  <= '0;
      rd_gray <= '0;
      rd_data <= '0;
      ae_q    <= 1'b1;
      rsel    <= SEL_AE;
    end else begin
      ae_q <= (fill_r <= ae_ofs);
      if (!rt_n) begin
        rd_bin  <= '0;
        rd_gray <= '0;
      end else if (rd_go) begin
        rd_bin  <= rd_next;
        rd_gray <= rd_next ^ (rd_next >> 1);
      end
      if (ofs_rd) begin
        rd_data <= {{(DW - PW){1'b0}}, (rsel == SEL_AE) ? ae_ofs : af_ofs};
        rsel    <= (rsel == SEL_AE) ? SEL_AF : SEL_AE;
      end else if (rd_go) begin
        rd_data <= mem_q;
      end
    end
  end
endmodule

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo
  import dcfifo_pkg::*;
#(
  parameter int DW      = DATA_W,
  parameter int DEPTH   = 16,
  parameter int OFS_RST = OFS_DEFAULT
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          wr_en_n,
  input  logic [DW-1:0] wr_data,
  input  logic          load_n,
  input  logic          rd_en_n,
  output logic [DW-1:0] rd_data,
  input  logic          rt_n,
  input  logic          sync_almost,
  output logic          empty_n,
  output logic          full_n,
  output logic          half_n,
  output logic          aempty_n,
  output logic          afull_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  logic [PW-1:0] wr_bin, wr_gray, rd_bin, rd_gray;
  logic [PW-1:0] wr_gray_s, rd_gray_s;
  logic [PW-1:0] ae_ofs, af_ofs;
  logic [PW-1:0] fill_a;
  logic [DW-1:0] mem_q;
  logic          mem_we;
  logic          afull_reg_n, aempty_reg_n;

  dcfifo_sync #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rst_n), .d(wr_gray), .q(wr_gray_s));
  dcfifo_sync #(.W(PW)) u_r2w (.clk(wclk), .rst_n(rst_n), .d(rd_gray), .q(rd_gray_s));

  dcfifo_mem #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .wclk (wclk),
    .we   (mem_we),
    .waddr(wr_bin[AW-1:0]),
    .wdata(wr_data),
    .raddr(rd_bin[AW-1:0]),
    .rdata(mem_q)
  );

  dcfifo_wr_ctl #(.DW(DW), .DEPTH(DEPTH), .PW(PW), .OFS_RST(OFS_RST)) u_wr (
    .wclk       (wclk),
    .rst_n      (rst_n),
    .wr_en_n    (wr_en_n),
    .load_n     (load_n),
    .wr_data    (wr_data),
    .rd_gray_s  (rd_gray_s),
    .wr_bin     (wr_bin),
    .wr_gray    (wr_gray),
    .mem_we     (mem_we),
    .full_n     (full_n),
    .half_n     (half_n),
    .afull_reg_n(afull_reg_n),
    .ae_ofs     (ae_ofs),
    .af_ofs     (af_ofs)
  );

  dcfifo_rd_ctl #(.DW(DW), .PW(PW)) u_rd (
    .rclk        (rclk),
    .rst_n       (rst_n),
    .rd_en_n     (rd_en_n),
    .load_n      (load_n),
    .rt_n        (rt_n),
    .wr_gray_s   (wr_gray_s),
    .ae_ofs      (ae_ofs),
    .af_ofs      (af_ofs),
    .mem_q       (mem_q),
    .rd_bin      (rd_bin),
    .rd_gray     (rd_gray),
    .rd_data     (rd_data),
    .empty_n     (empty_n),
    .aempty_reg_n(aempty_reg_n)
  );

  // clockless almost flags from the raw pointers of both domains
  assign fill_a = wr_bin - rd_bin;

  always_comb begin
    if (sync_almost) begin
      aempty_n = aempty_reg_n;
      afull_n  = afull_reg_n;
    end else begin
      aempty_n = !(fill_a <= ae_ofs);
      afull_n  = !((DEPTH_P - fill_a) <= af_ofs);
    end
  end
endmodule

// File: rtl/dcfifo_chk.sv
module dcfifo_chk #(
  parameter int DEPTH = 16,
  parameter int PW    = 5
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst_n,
  input logic          wr_en_n,
  input logic          rd_en_n,
  input logic          load_n,
  input logic          rt_n,
  input logic          full_n,
  input logic          empty_n,
  input logic          half_n,
  input logic [PW-1:0] wr_bin,
  input logic [PW-1:0] rd_bin
);
  // R1
  no_overflow_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (!full_n && !wr_en_n && load_n) |=> $stable(wr_bin));

  // R2
  no_underflow_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (!empty_n && !rd_en_n && load_n && rt_n) |=> $stable(rd_bin));

  // R3
  load_keeps_wptr_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (!load_n) |=> $stable(wr_bin));

  // R7
  full_implies_half_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (!full_n) |-> (!half_n));

  // R11
  rewind_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (!rt_n) |=> (rd_bin == '0));

  // R6
  fill_bound_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (PW'(wr_bin - rd_bin) <= PW'(DEPTH)));
endmodule

bind dual_clock_fifo dcfifo_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (
  .wclk   (wclk),
  .rclk   (rclk),
  .rst_n  (rst_n),
  .wr_en_n(wr_en_n),
  .rd_en_n(rd_en_n),
  .load_n (load_n),
  .rt_n   (rt_n),
  .full_n (full_n),
  .empty_n(empty_n),
  .half_n (half_n),
  .wr_bin (wr_bin),
  .rd_bin (rd_bin)
);

// File: tb/sim_dual_clock_fifo.sv
module sim_dual_clock_fifo;
  localparam int DW    = 18;
  localparam int DEPTH = 16;

  logic          wclk = 1'b0;
  logic          rclk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en_n = 1'b1;
  logic [DW-1:0] wr_data = '0;
  logic          load_n = 1'b1;
  logic          rd_en_n = 1'b1;
  logic [DW-1:0] rd_data;
  logic          rt_n = 1'b1;
  logic          sync_almost = 1'b1;
  logic          empty_n, full_n, half_n, aempty_n, afull_n;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #10 wclk = ~wclk;  // 50 MHz
  always #15 rclk = ~rclk;

  dual_clock_fifo #(.DW(DW), .DEPTH(DEPTH)) u0 (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
    .wr_en_n(wr_en_n), .wr_data(wr_data), .load_n(load_n),
    .rd_en_n(rd_en_n), .rd_data(rd_data), .rt_n(rt_n),
    .sync_almost(sync_almost),
    .empty_n(empty_n), .full_n(full_n), .half_n(half_n),
    .aempty_n(aempty_n), .afull_n(afull_n)
  );

  function automatic logic [DW-1:0] dval(input int k);
    return DW'((k * 1237 + 91) ^ (k << 11));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge rclk);
    repeat (6) @(negedge wclk);
  endtask

  task automatic do_reset();
    @(negedge wclk);
    rst_n = 1'b0;
    repeat (2) @(negedge wclk);
    rst_n = 1'b1;
    settle();
  endtask

  task automatic wr_word(input logic [DW-1:0] d);
    @(negedge wclk);
    wr_en_n = 1'b0;
    wr_data = d;
    @(negedge wclk);
    wr_en_n = 1'b1;
  endtask

  task automatic rd_word();
    @(negedge rclk);
    rd_en_n = 1'b0;
    @(negedge rclk);
    rd_en_n = 1'b1;
  endtask

  task automatic ld_wr(input logic [DW-1:0] d);
    @(negedge wclk);
    load_n  = 1'b0;
    wr_en_n = 1'b0;
    wr_data = d;
    @(negedge wclk);
    wr_en_n = 1'b1;
    load_n  = 1'b1;
  endtask

  task automatic ld_rd();
    @(negedge rclk);
    load_n  = 1'b0;
    rd_en_n = 1'b0;
    @(negedge rclk);
    rd_en_n = 1'b1;
    load_n  = 1'b1;
  endtask

  initial begin
    do_reset();
    // R10 reset state
    check("R10 empty_n", 32'(empty_n), 0);
    check("R10 full_n", 32'(full_n), 1);
    check("R10 half_n", 32'(half_n), 1);
    check("R10 aempty_n", 32'(aempty_n), 0);
    check("R10 afull_n", 32'(afull_n), 1);
    ld_rd(); check("R10 default ae offset", 32'(rd_data), 7);
    ld_rd(); check("R10 default af offset", 32'(rd_data), 7);

    // R3 / R4 offset programming order
    ld_wr(18'h3FF03);  // ae (only low bits kept)
    ld_wr(18'h00002);  // af
    ld_wr(18'h00004);  // ae again
    ld_rd(); check("R4 ae readback", 32'(rd_data), 4);
    ld_rd(); check("R4 af readback", 32'(rd_data), 2);
    ld_rd(); check("R4 order wraps to ae", 32'(rd_data), 4);
    settle();
    check("R3 load leaves fifo empty", 32'(empty_n), 0);

    // fill sweep: ae=4, af=2, registered flags
    for (int k = 1; k <= DEPTH; k++) begin
      wr_word(dval(k));
      settle();
      check("R5 empty_n while filling", 32'(empty_n), 1);
      check("R6 full_n", 32'(full_n), (k == DEPTH) ? 0 : 1);
      check("R7 half_n", 32'(half_n), (k > DEPTH / 2) ? 0 : 1);
      check("R8 aempty_n", 32'(aempty_n), (k <= 4) ? 0 : 1);
      check("R8 afull_n", 32'(afull_n), ((DEPTH - k) <= 2) ? 0 : 1);
    end
    wr_word(18'h3FFFF);  // R1 write while full is dropped
    settle();
    check("R1 still full", 32'(full_n), 0);

    // drain sweep
    for (int i = 1; i <= DEPTH; i++) begin
      rd_word();
      check("R2 read data order", 32'(rd_data), 32'(dval(i)));
      settle();
      check("R5 empty_n while draining", 32'(empty_n), (i == DEPTH) ? 0 : 1);
      check("R6 full_n after read", 32'(full_n), 1);
      check("R8 aempty_n draining", 32'(aempty_n), ((DEPTH - i) <= 4) ? 0 : 1);
    end
    rd_word();  // R2 read while empty
    check("R2 empty read keeps rd_data", 32'(rd_data), 32'(dval(DEPTH)));

    // R11 retransmit
    @(negedge rclk); rt_n = 1'b0;
    @(negedge rclk); rt_n = 1'b1;
    settle();
    check("R11 fifo refilled empty_n", 32'(empty_n), 1);
    check("R11 fifo refilled full_n", 32'(full_n), 0);
    for (int i = 1; i <= DEPTH; i++) begin
      rd_word();
      check("R11 replay data", 32'(rd_data), 32'(dval(i)));
    end
    settle();
    check("R11 empty after replay", 32'(empty_n), 0);

    // R9 combinational almost flags
    sync_almost = 1'b0;
    do_reset();
    for (int k = 1; k <= 7; k++) wr_word(dval(k));
    settle();
    check("R9 comb aempty_n at offset", 32'(aempty_n), 0);
    wr_word(dval(8));
    check("R9 comb aempty_n immediate", 32'(aempty_n), 1);
    wr_word(dval(9));
    check("R9 comb afull_n immediate", 32'(afull_n), 0);

    // R9 registered almost flags lag
    sync_almost = 1'b1;
    do_reset();
    for (int k = 1; k <= 7; k++) wr_word(dval(k));
    settle();
    wr_word(dval(8));
    check("R9 reg aempty_n not yet", 32'(aempty_n), 0);
    wr_word(dval(9));
    check("R9 reg afull_n not yet", 32'(afull_n), 1);
    settle();
    check("R9 reg aempty_n later", 32'(aempty_n), 1);
    check("R9 reg afull_n later", 32'(afull_n), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge wclk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule